// File: doc/BRIEF.md
# Interlaced Field and Line Timing Generator

This block keeps the vertical timing of a 625-line interlaced raster. A one-clock line tick arrives once every 64 µs. On each tick the block steps a line number within the current field. Fields alternate between a 312-line first field and a 313-line second field, and the block counts frames so that it always knows whether the current frame is odd or even. From the line number it decodes a data acquisition window near the top of each field and a display region. The display region is cut into character rows, each as tall as one character cell.

An external vertical sync pulse, qualified by the line tick, pulls the counter back to line 1. A sync that arrives exactly on time, or one line early or late, is accepted quietly. Any other sync realigns the counter and raises a lock-lost flag, which stays up until a sync arrives exactly on time.

An odd/even status output announces the frame parity a fixed number of clocks before the end of frame lines 311 and 624. A down-counter reloaded at every line start measures that lead time. The block has three small state machines:
- The field machine has the states FLD_FIRST and FLD_SECOND. A wrap or a resync toggles it, except for a late sync, which keeps the field.
- The region machine has the states RG_TOP, RG_ROWS and RG_BOTTOM. RG_TOP moves to RG_ROWS when the first display line starts. RG_ROWS moves to RG_BOTTOM after the last scan line of the last row. Any line 1 returns it to RG_TOP.
- The lead timer has the states TM_IDLE and TM_RUN. A tick moves it to TM_RUN. It returns to TM_IDLE when the count reaches zero, and that return issues the lead strobe.

Each tick is sorted into one of five sync classes: SY_NONE, SY_ONTIME, SY_EARLY, SY_LATE and SY_STRAY.

Top module: `field_line_timer`

## Requirements
- R1: After reset the block shows line 1 of the first field with field_id 0. odd_even, acq_win, disp_win, disp_row, field_start and lock_lost are all 0.
- R2: line_num and field_id change only at a clock edge where line_tick is high. Without a tick they hold for any number of cycles.
- R3: Without vsync, each tick increments line_num. The tick that ends the last line of a field starts line 1 of the other field. The first field (field_id 0) is 312 lines long and the second field (field_id 1) is 313 lines long.
- R4: acq_win is high exactly while line_num is between 2 and 22 inclusive, in either field.
- R5: disp_win is high for the 250 lines starting at line 41. disp_row is 0 before that region and advances by one every 10 lines inside it, so disp_row = (line_num-41)/10. It holds at 24 after the region until the next line 1.
- R6: field_start is high for exactly the one cycle after each tick that begins line 1.
- R7: odd_even is 1 for even frames and 0 for odd frames, and the frame after reset is frame 1. It updates LEAD_CLKS clocks before the tick that ends a field's next-to-last line, which is frame line 311 or 624. At frame line 311 it takes the parity of the current frame. At frame line 624 it takes the parity of the next frame. It changes at no other time.
- R8: A tick with vsync on the last line of a field wraps to line 1 of the other field, exactly as a plain wrap does, and clears lock_lost.
- R9: A tick with vsync on the next-to-last line of a field (one line early) starts line 1 of the other field and leaves lock_lost unchanged.
- R10: A tick with vsync on line 1 (one line late) restarts line 1 of the same field, gives another field_start pulse, and leaves lock_lost unchanged.
- R11: A tick with vsync on any other line starts line 1 of the other field and sets lock_lost. lock_lost stays set until an on-time sync as in R8.
- R12: vsync high while line_tick is low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-clock pulse at the start of every line |
| vsync | input | 1 | Vertical sync, sampled only together with line_tick |
| line_num | output | 9 | Line number within the current field, starting at 1 |
| field_id | output | 1 | 0 for the first (312-line) field, 1 for the second (313-line) field |
| odd_even | output | 1 | Frame parity status, 1 for an even frame |
| acq_win | output | 1 | Acquisition window flag (lines 2 to 22) |
| disp_win | output | 1 | Display region flag |
| disp_row | output | 5 | Character row index, 0 to 24 |
| field_start | output | 1 | One-clock pulse at the start of line 1 |
| lock_lost | output | 1 | An out-of-window sync was seen and no on-time sync has followed |

## Verification
line_num, field_id, acq_win, disp_win, disp_row, field_start and lock_lost all change at the same edge that samples a tick. They are therefore checked at the falling edge just after that tick, and field_start is checked again one cycle later for its return to 0. odd_even flips at the edge LINE_CLKS-LEAD_CLKS clocks after a tick. The bench samples it at the falling edge one clock before that point and at the falling edge just after it, on every line of two full frames, so an early or late change is caught. Expected line, field and parity values come from the tick count since reset through division and remainder by 625. The resync cases are driven at chosen lines and checked on the line that follows.

// File: rtl/fldtm_pkg.sv
package fldtm_pkg;

    typedef enum logic {
        FLD_FIRST  = 1'b0,
        FLD_SECOND = 1'b1
    } fld_e;

    typedef enum logic [1:0] {
        RG_TOP,
        RG_ROWS,
        RG_BOTTOM
    } rgn_e;

    typedef enum logic {
        TM_IDLE,
        TM_RUN
    } tmr_e;

    typedef enum logic [2:0] {
        SY_NONE,
        SY_ONTIME,
        SY_EARLY,
        SY_LATE,
        SY_STRAY
    } sync_e;

endpackage

// File: rtl/fldtm_line_ctr.sv
module fldtm_line_ctr
    import fldtm_pkg::*;
#(
    parameter int LW         = 9,
    parameter int FIRST_LEN  = 312,
    parameter int SECOND_LEN = 313
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          vsync,
    output logic [LW-1:0] line_q,
    output logic [LW-1:0] line_nxt,
    output fld_e          fld_q,
    output logic          frame_even_q,
    output logic          lock_lost_q,
    output logic          start_q
);

    localparam logic [LW-1:0] LEN_A = LW'(FIRST_LEN);
    localparam logic [LW-1:0] LEN_B = LW'(SECOND_LEN);
    localparam logic [LW-1:0] ONE   = LW'(1);

    logic [LW-1:0] cur_len;
    sync_e         sy;
    fld_e          fld_d;
    fld_e          fld_flip;
    logic          lock_d;
    logic          even_d;

    // Classify the tick against the expected field end.
    always_comb begin
        cur_len  = (fld_q == FLD_SECOND) ? LEN_B : LEN_A;
        fld_flip = (fld_q == FLD_FIRST) ? FLD_SECOND : FLD_FIRST;
        if (!(tick && vsync))            sy = SY_NONE;
        else if (line_q == cur_len)      sy = SY_ONTIME;
        else if (line_q == cur_len - ONE) sy = SY_EARLY;
        else if (line_q == ONE)          sy = SY_LATE;
        else                             sy = SY_STRAY;
    end

    // Next-state logic of the field machine and the line counter.
    always_comb begin
        line_nxt = line_q;
        fld_d    = fld_q;
        lock_d   = lock_lost_q;
        unique case (sy)
            SY_NONE: begin
                if (tick) begin
                    if (line_q == cur_len) begin
                        line_nxt = ONE;
                        fld_d    = fld_flip;
                    end else begin
                        line_nxt = line_q + ONE;
                    end
                end
            end
            SY_ONTIME: begin
                line_nxt = ONE;
                fld_d    = fld_flip;
                lock_d   = 1'b0;
            end
            SY_EARLY: begin
                line_nxt = ONE;
                fld_d    = fld_flip;
            end
            SY_LATE: begin
                line_nxt = ONE;
            end
            SY_STRAY: begin
                line_nxt = ONE;
                fld_d    = fld_flip;
                lock_d   = 1'b1;
            end
        endcase
        even_d = frame_even_q ^ ((fld_q == FLD_SECOND) && (fld_d == FLD_FIRST));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q       <= ONE;
            fld_q        <= FLD_FIRST;
            frame_even_q <= 1'b0;
            lock_lost_q  <= 1'b0;
            start_q      <= 1'b0;
        end else begin
            line_q       <= line_nxt;
            fld_q        <= fld_d;
            frame_even_q <= even_d;
            lock_lost_q  <= lock_d;
            start_q      <= tick && (line_nxt == ONE);
        end
    end

endmodule

// File: rtl/fldtm_lead_tmr.sv
module fldtm_lead_tmr
    import fldtm_pkg::*;
#(
    parameter int LINE_CLKS = 1024,
    parameter int LEAD_CLKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic expire
);

    localparam int            CW   = $clog2(LINE_CLKS);
    localparam logic [CW-1:0] LOAD = CW'(LINE_CLKS - LEAD_CLKS - 1);
    localparam logic [CW-1:0] ZERO = '0;
    localparam logic [CW-1:0] STEP = CW'(1);

    tmr_e          st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= TM_IDLE;
            cnt_q <= ZERO;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (tick) begin
            st_d  = TM_RUN;
            cnt_d = LOAD;
        end else begin
            unique case (st_q)
                TM_IDLE: begin
                    st_d = TM_IDLE;
                end
                TM_RUN: begin
                    if (cnt_q == ZERO) begin
                        expire = 1'b1;
                        st_d   = TM_IDLE;
                    end else begin
                        cnt_d = cnt_q - STEP;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/fldtm_region_fsm.sv
module fldtm_region_fsm
    import fldtm_pkg::*;
#(
    parameter int LW         = 9,
    parameter int DISP_FIRST = 41,
    parameter int ROW_LINES  = 10,
    parameter int ROWS       = 25
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic [LW-1:0]           line_nxt,
    output logic                    disp_win,
    output logic [$clog2(ROWS)-1:0] row_q
);

    localparam int            RW        = $clog2(ROWS);
    localparam int            SW        = $clog2(ROW_LINES);
    localparam logic [LW-1:0] ONE       = LW'(1);
    localparam logic [LW-1:0] FIRST_ROW = LW'(DISP_FIRST);
    localparam logic [SW-1:0] SCAN_LAST = SW'(ROW_LINES - 1);
    localparam logic [RW-1:0] ROW_LAST  = RW'(ROWS - 1);

    rgn_e          st_q, st_d;
    logic [SW-1:0] scan_q, scan_d;
    logic [RW-1:0] row_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= RG_TOP;
            scan_q <= '0;
            row_q  <= '0;
        end else begin
            st_q   <= st_d;
            scan_q <= scan_d;
            row_q  <= row_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        scan_d = scan_q;
        row_d  = row_q;
        if (tick) begin
            if (line_nxt == ONE) begin
                st_d   = RG_TOP;
                scan_d = '0;
                row_d  = '0;
            end else begin
                unique case (st_q)
                    RG_TOP: begin
                        if (line_nxt == FIRST_ROW) begin
                            st_d   = RG_ROWS;
                            scan_d = '0;
                            row_d  = '0;
                        end
                    end
                    RG_ROWS: begin
                        if (scan_q == SCAN_LAST) begin
                            scan_d = '0;
                            if (row_q == ROW_LAST) st_d = RG_BOTTOM;
                            else                   row_d = row_q + RW'(1);
                        end else begin
                            scan_d = scan_q + SW'(1);
                        end
                    end
                    RG_BOTTOM: begin
                        st_d = RG_BOTTOM;
                    end
                    default: st_d = RG_TOP;
                endcase
            end
        end
    end

    // Output decode from the region state.
    always_comb begin
        unique case (st_q)
            RG_ROWS: disp_win = 1'b1;
            default: disp_win = 1'b0;
        endcase
    end

endmodule

// File: rtl/field_line_timer.sv
module field_line_timer
    import fldtm_pkg::*;
#(
    parameter int LINE_CLKS  = 1024,
    parameter int LEAD_CLKS  = 32,
    parameter int FIRST_LEN  = 312,
    parameter int SECOND_LEN = 313,
    parameter int ACQ_FIRST  = 2,
    parameter int ACQ_LAST   = 22,
    parameter int DISP_FIRST = 41,
    parameter int ROW_LINES  = 10,
    parameter int ROWS       = 25
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              line_tick,
    input  logic                              vsync,
    output logic [$clog2(SECOND_LEN+1)-1:0]   line_num,
    output logic                              field_id,
    output logic                              odd_even,
    output logic                              acq_win,
    output logic                              disp_win,
    output logic [$clog2(ROWS)-1:0]           disp_row,
    output logic                              field_start,
    output logic                              lock_lost
);

    localparam int            LW      = $clog2(SECOND_LEN + 1);
    localparam logic [LW-1:0] ACQ_LO  = LW'(ACQ_FIRST);
    localparam logic [LW-1:0] ACQ_HI  = LW'(ACQ_LAST);
    localparam logic [LW-1:0] LEAD_A  = LW'(FIRST_LEN - 1);
    localparam logic [LW-1:0] LEAD_B  = LW'(SECOND_LEN - 1);

    logic [LW-1:0] line_q;
    logic [LW-1:0] line_nxt;
    fld_e          fld_q;
    logic          frame_even_q;
    logic          lead_hit;
    logic          oe_q;

    fldtm_line_ctr #(
        .LW        (LW),
        .FIRST_LEN (FIRST_LEN),
        .SECOND_LEN(SECOND_LEN)
    ) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (line_tick),
        .vsync       (vsync),
        .line_q      (line_q),
        .line_nxt    (line_nxt),
        .fld_q       (fld_q),
        .frame_even_q(frame_even_q),
        .lock_lost_q (lock_lost),
        .start_q     (field_start)
    );

    fldtm_lead_tmr #(
        .LINE_CLKS(LINE_CLKS),
        .LEAD_CLKS(LEAD_CLKS)
    ) u_lead (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (line_tick),
        .expire(lead_hit)
    );

    fldtm_region_fsm #(
        .LW        (LW),
        .DISP_FIRST(DISP_FIRST),
        .ROW_LINES (ROW_LINES),
        .ROWS      (ROWS)
    ) u_region (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (line_tick),
        .line_nxt(line_nxt),
        .disp_win(disp_win),
        .row_q   (disp_row)
    );

    // Odd/even announcement at the lead point of each field's next-to-last line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (lead_hit) begin
            if (fld_q == FLD_FIRST && line_q == LEAD_A)
                oe_q <= frame_even_q;
            else if (fld_q == FLD_SECOND && line_q == LEAD_B)
                oe_q <= ~frame_even_q;
        end
    end

    assign line_num = line_q;
    assign field_id = (fld_q == FLD_SECOND);
    assign odd_even = oe_q;
    assign acq_win  = (line_q >= ACQ_LO) && (line_q <= ACQ_HI);

endmodule

// File: rtl/fldtm_chk.sv
module fldtm_chk #(
    parameter int FIRST_LEN  = 312,
    parameter int SECOND_LEN = 313,
    parameter int ROWS       = 25
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            line_tick,
    input logic                            vsync,
    input logic [$clog2(SECOND_LEN+1)-1:0] line_num,
    input logic                            field_id,
    input logic                            odd_even,
    input logic                            acq_win,
    input logic                            disp_win,
    input logic [$clog2(ROWS)-1:0]         disp_row,
    input logic                            field_start,
    input logic                            lock_lost
);

    localparam int            LW     = $clog2(SECOND_LEN + 1);
    localparam int            RW     = $clog2(ROWS);
    localparam logic [LW-1:0] LEN_A  = LW'(FIRST_LEN);
    localparam logic [LW-1:0] LEN_B  = LW'(SECOND_LEN);
    localparam logic [LW-1:0] PRE_A  = LW'(FIRST_LEN - 1);
    localparam logic [LW-1:0] PRE_B  = LW'(SECOND_LEN - 1);
    localparam logic [LW-1:0] ONE    = LW'(1);
    localparam logic [RW-1:0] RMAX   = RW'(ROWS - 1);

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> ($stable(line_num) && $stable(field_id)));

    assert_line_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_num >= ONE) && (line_num <= (field_id ? LEN_B : LEN_A)));

    assert_windows_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(acq_win && disp_win));

    assert_row_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_row <= RMAX);

    assert_row_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_row != $past(disp_row)) |-> $past(line_tick));

    assert_start_line1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |-> (line_num == ONE));

    assert_oe_point_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (odd_even != $past(odd_even)) |->
            (!$past(line_tick) &&
             ((!field_id && line_num == PRE_A) || (field_id && line_num == PRE_B))));

    assert_lock_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_lost) |-> ($past(line_tick && vsync) && line_num == ONE));

    assert_lock_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_lost) |-> $past(line_tick && vsync));

    assert_vsync_alone_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && !line_tick) |=> ($stable(lock_lost) && $stable(line_num)));

endmodule

bind field_line_timer fldtm_chk #(
    .FIRST_LEN (FIRST_LEN),
    .SECOND_LEN(SECOND_LEN),
    .ROWS      (ROWS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_tick  (line_tick),
    .vsync      (vsync),
    .line_num   (line_num),
    .field_id   (field_id),
    .odd_even   (odd_even),
    .acq_win    (acq_win),
    .disp_win   (disp_win),
    .disp_row   (disp_row),
    .field_start(field_start),
    .lock_lost  (lock_lost)
);

// File: tb/tb_field_line_timer.sv
module tb_field_line_timer;

    localparam int CLK_PERIOD = 10;
    localparam int LINE       = 16;
    localparam int LEAD       = 2;
    localparam int FRAME      = 625;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_tick = 1'b0;
    logic       vsync = 1'b0;
    logic [8:0] line_num;
    logic       field_id;
    logic       odd_even;
    logic       acq_win;
    logic       disp_win;
    logic [4:0] disp_row;
    logic       field_start;
    logic       lock_lost;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;
    int  exp_oe = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    field_line_timer #(
        .LINE_CLKS(LINE),
        .LEAD_CLKS(LEAD)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_tick  (line_tick),
        .vsync      (vsync),
        .line_num   (line_num),
        .field_id   (field_id),
        .odd_even   (odd_even),
        .acq_win    (acq_win),
        .disp_win   (disp_win),
        .disp_row   (disp_row),
        .field_start(field_start),
        .lock_lost  (lock_lost)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Tick (optionally with vsync) and return at the falling edge after it.
    task automatic do_tick(input bit vs);
        line_tick = 1'b1;
        vsync     = vs;
        @(posedge clk);
        @(negedge clk);
        line_tick = 1'b0;
        vsync     = 1'b0;
    endtask

    // Remaining clocks of the line; optionally check odd_even around the lead point.
    task automatic finish_line(input bit oe_chk, input int ln, input int fld, input int frm);
        for (int c = 1; c < LINE; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c == 1 && oe_chk && ln == 1)
                chk("R6", "field_start low", int'(field_start), 0);
            if (oe_chk && c == LINE - LEAD - 1)
                chk("R7", "odd_even before lead", int'(odd_even), exp_oe);
            if (oe_chk && c == LINE - LEAD) begin
                if (fld == 0 && ln == 311) exp_oe = frm % 2;
                if (fld == 1 && ln == 312) exp_oe = (frm + 1) % 2;
                chk("R7", "odd_even after lead", int'(odd_even), exp_oe);
            end
        end
    endtask

    task automatic adv(input int tl, input int tf);
        int guard;
        guard = 0;
        while (!(int'(line_num) == tl && int'(field_id) == tf) && guard < 700) begin
            do_tick(1'b0);
            finish_line(1'b0, 0, 0, 0);
            guard++;
        end
        chk("R3", "reached target line", int'(line_num), tl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "line_num", int'(line_num), 1);
        chk("R1", "field_id", int'(field_id), 0);
        chk("R1", "odd_even", int'(odd_even), 0);
        chk("R1", "acq_win", int'(acq_win), 0);
        chk("R1", "disp_win", int'(disp_win), 0);
        chk("R1", "disp_row", int'(disp_row), 0);
        chk("R1", "field_start", int'(field_start), 0);
        chk("R1", "lock_lost", int'(lock_lost), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep two frames and a bit with expected values from the tick count.
        for (int n = 1; n <= 1300; n++) begin
            int p, frm, fld, ln, row;
            do_tick(1'b0);
            p   = n % FRAME;
            frm = n / FRAME;
            fld = (p >= 312) ? 1 : 0;
            ln  = (fld == 1) ? p - 311 : p + 1;
            row = (ln < 41) ? 0 : (((ln - 41) / 10 > 24) ? 24 : (ln - 41) / 10);
            chk("R3", "line_num", int'(line_num), ln);
            chk("R3", "field_id", int'(field_id), fld);
            chk("R4", "acq_win", int'(acq_win), (ln >= 2 && ln <= 22) ? 1 : 0);
            chk("R5", "disp_win", int'(disp_win), (ln >= 41 && ln <= 290) ? 1 : 0);
            chk("R5", "disp_row", int'(disp_row), row);
            chk("R6", "field_start", int'(field_start), (ln == 1) ? 1 : 0);
            chk("R11", "lock_lost quiet", int'(lock_lost), 0);
            finish_line(1'b1, ln, fld, frm);
        end

        // R12: vsync without a tick changes nothing.
        chk("R3", "after sweep line", int'(line_num), 51);
        vsync = 1'b1;
        @(posedge clk);
        @(negedge clk);
        vsync = 1'b0;
        chk("R12", "line_num after lone vsync", int'(line_num), 51);
        chk("R12", "lock_lost after lone vsync", int'(lock_lost), 0);
        do_tick(1'b0);
        chk("R12", "next line after lone vsync", int'(line_num), 52);
        chk("R12", "field after lone vsync", int'(field_id), 0);
        finish_line(1'b0, 0, 0, 0);

        // R9: one line early in the first field.
        adv(311, 0);
        do_tick(1'b1);
        chk("R9", "early line_num", int'(line_num), 1);
        chk("R9", "early field_id", int'(field_id), 1);
        chk("R9", "early lock_lost", int'(lock_lost), 0);
        chk("R9", "early field_start", int'(field_start), 1);
        finish_line(1'b0, 0, 0, 0);

        // R8: on time at the end of the second field.
        adv(313, 1);
        do_tick(1'b1);
        chk("R8", "ontime line_num", int'(line_num), 1);
        chk("R8", "ontime field_id", int'(field_id), 0);
        chk("R8", "ontime lock_lost", int'(lock_lost), 0);
        finish_line(1'b0, 0, 0, 0);

        // R10: one line late, on line 1.
        do_tick(1'b1);
        chk("R10", "late line_num", int'(line_num), 1);
        chk("R10", "late field_id", int'(field_id), 0);
        chk("R10", "late field_start", int'(field_start), 1);
        chk("R10", "late lock_lost", int'(lock_lost), 0);
        finish_line(1'b0, 0, 0, 0);
        do_tick(1'b0);
        chk("R10", "line after late", int'(line_num), 2);
        finish_line(1'b0, 0, 0, 0);

        // R11: stray sync sets lock_lost until an on-time sync.
        adv(100, 0);
        do_tick(1'b1);
        chk("R11", "stray line_num", int'(line_num), 1);
        chk("R11", "stray field_id", int'(field_id), 1);
        chk("R11", "stray lock_lost", int'(lock_lost), 1);
        finish_line(1'b0, 0, 0, 0);
        adv(200, 1);
        chk("R11", "lock_lost held", int'(lock_lost), 1);
        adv(312, 1);
        do_tick(1'b1);
        chk("R9", "early keeps lock_lost", int'(lock_lost), 1);
        chk("R9", "early from second field", int'(field_id), 0);
        finish_line(1'b0, 0, 0, 0);
        adv(312, 0);
        do_tick(1'b1);
        chk("R8", "ontime first field wrap", int'(field_id), 1);
        chk("R8", "ontime clears lock_lost", int'(lock_lost), 0);
        finish_line(1'b0, 0, 0, 0);

        // R2: no tick, no movement.
        repeat (40) @(negedge clk);
        chk("R2", "line_num held", int'(line_num), 1);
        chk("R2", "field_id held", int'(field_id), 1);
        chk("R6", "field_start idle", int'(field_start), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule